// File: doc/BRIEF.md
# Register-Read Operand Forwarding Network

This block resolves the two source operands of an instruction at the register-read stage of an in-order pipeline. Every later stage (execute, memory, writeback, and the register-file write port in the same cycle) offers one forwarding source: a valid flag, a destination register index and the value being produced. For each operand the block combines the external register-file read value, the external scoreboard busy bit and these sources. It returns the operand value, a flag showing that the value was forwarded, and a single stall request for the stage.

A register that the scoreboard reports as free is read straight from the register file. A busy register is taken from the earliest pipeline stage whose source matches it. If no source matches, the stage must stall. Register 0 is hard-wired to zero. Both operands are resolved in parallel by purely combinational logic, so results appear in the same cycle as the inputs.

Top module: `opfwd_top`

## Requirements
- R1: An operand whose register index is 0 yields the value 0, has its forwarded flag low and never causes a stall, even if a valid source names index 0 and the scoreboard reports it busy.
- R2: An operand with a nonzero index that the scoreboard reports not busy yields the register-file value with its forwarded flag low, even when a valid source matches its index.
- R3: A busy operand with a nonzero index that exactly one valid source matches yields that source's data with the forwarded flag high; this holds for each of the four sources.
- R4: When several valid sources match a busy operand, the lowest-numbered source wins. The numbering is 0 = execute, 1 = memory, 2 = writeback, 3 = same-cycle register-file write.
- R5: A source whose valid flag is low, or whose index differs from the operand index, never supplies the operand.
- R6: A used operand that is busy, has a nonzero index and has no matching valid source raises the stall output and keeps its forwarded flag low.
- R7: The stall output is low when every used busy operand is supplied by a source.
- R8: An operand whose use flag is low never causes a stall.
- R9: The two operands are resolved independently in the same cycle. Each may be supplied by a different source, or one may be forwarded while the other comes from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_vld | input | NSRC | Valid flag of each forwarding source, bit 0 = execute |
| src_idx | input | NSRC*IW | Destination index of each source, source s in bits [s*IW +: IW] |
| src_data | input | NSRC*DW | Value of each source, source s in bits [s*DW +: DW] |
| opa_idx | input | IW | Register index of operand A |
| opb_idx | input | IW | Register index of operand B |
| opa_use | input | 1 | Operand A is needed by the instruction |
| opb_use | input | 1 | Operand B is needed by the instruction |
| opa_busy | input | 1 | Scoreboard busy bit of operand A's register |
| opb_busy | input | 1 | Scoreboard busy bit of operand B's register |
| rfa_data | input | DW | Register-file read value for operand A |
| rfb_data | input | DW | Register-file read value for operand B |
| opa_data | output | DW | Resolved value of operand A |
| opb_data | output | DW | Resolved value of operand B |
| opa_fwd | output | 1 | Operand A was taken from a forwarding source |
| opb_fwd | output | 1 | Operand B was taken from a forwarding source |
| rd_stall | output | 1 | Register read must hold this instruction |

## Verification
Priority selection and stall generation can act in the same cycle: one operand picks among several matching sources while the other is busy with no match. The bench sets up all four sources on operand A's index with distinct values and leaves operand B uncovered. It then expects execute's value on A, forwarded flag high, and a stall that comes from B alone. Removing B's use flag in the following step must clear the stall while leaving A's selection unchanged.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  typedef enum int unsigned {
    STG_EXE = 0,
    STG_MEM = 1,
    STG_WB  = 2,
    STG_RFW = 3,
    STG_CNT = 4
  } fwd_stage_e;

  localparam int unsigned FWD_IW = 5;
  localparam int unsigned FWD_DW = 32;

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned IW   = 5,
  parameter int unsigned DW   = 32
) (
  input  logic [NSRC-1:0]    src_vld,
  input  logic [NSRC*IW-1:0] src_idx,
  input  logic [NSRC*DW-1:0] src_data,
  input  logic [IW-1:0]      key_idx,
  output logic               hit_any,
  output logic [DW-1:0]      hit_data
);

  logic [NSRC-1:0] hit_vec;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
      assign hit_vec[s] = src_vld[s] && (src_idx[s*IW +: IW] == key_idx);
    end
  endgenerate

  // walk from the latest stage down so the earliest matching stage is kept
  always_comb begin
    hit_data = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (hit_vec[s]) hit_data = src_data[s*DW +: DW];
    end
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/opfwd_opnd.sv
module opfwd_opnd #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned IW   = 5,
  parameter int unsigned DW   = 32
) (
  input  logic [NSRC-1:0]    src_vld,
  input  logic [NSRC*IW-1:0] src_idx,
  input  logic [NSRC*DW-1:0] src_data,
  input  logic [IW-1:0]      op_idx,
  input  logic               op_busy,
  input  logic [DW-1:0]      rf_data,
  output logic [DW-1:0]      op_data,
  output logic               op_fwd,
  output logic               op_ready
);

  logic          is_zero;
  logic          m_any;
  logic [DW-1:0] m_data;

  opfwd_match #(.NSRC(NSRC), .IW(IW), .DW(DW)) i_match (
    .src_vld  (src_vld),
    .src_idx  (src_idx),
    .src_data (src_data),
    .key_idx  (op_idx),
    .hit_any  (m_any),
    .hit_data (m_data)
  );

  assign is_zero = (op_idx == '0);

  always_comb begin
    op_data  = rf_data;
    op_fwd   = 1'b0;
    op_ready = 1'b1;
    if (is_zero) begin
      op_data = '0;
    end else if (op_busy) begin
      if (m_any) begin
        op_data = m_data;
        op_fwd  = 1'b1;
      end else begin
        op_ready = 1'b0;
      end
    end
  end

endmodule

// File: rtl/opfwd_top.sv
module opfwd_top
  import opfwd_pkg::*;
#(
  parameter int unsigned NSRC = STG_CNT,
  parameter int unsigned IW   = FWD_IW,
  parameter int unsigned DW   = FWD_DW
) (
  input  logic [NSRC-1:0]    src_vld,
  input  logic [NSRC*IW-1:0] src_idx,
  input  logic [NSRC*DW-1:0] src_data,
  input  logic [IW-1:0]      opa_idx,
  input  logic [IW-1:0]      opb_idx,
  input  logic               opa_use,
  input  logic               opb_use,
  input  logic               opa_busy,
  input  logic               opb_busy,
  input  logic [DW-1:0]      rfa_data,
  input  logic [DW-1:0]      rfb_data,
  output logic [DW-1:0]      opa_data,
  output logic [DW-1:0]      opb_data,
  output logic               opa_fwd,
  output logic               opb_fwd,
  output logic               rd_stall
);

  localparam int unsigned NOP = 2;

  logic [NOP-1:0][IW-1:0] k_idx;
  logic [NOP-1:0][DW-1:0] k_rf;
  logic [NOP-1:0][DW-1:0] k_out;
  logic [NOP-1:0]         k_busy;
  logic [NOP-1:0]         k_use;
  logic [NOP-1:0]         k_fwd;
  logic [NOP-1:0]         k_rdy;

  assign k_idx  = {opb_idx, opa_idx};
  assign k_rf   = {rfb_data, rfa_data};
  assign k_busy = {opb_busy, opa_busy};
  assign k_use  = {opb_use, opa_use};

  generate
    for (genvar k = 0; k < NOP; k++) begin : g_op
      opfwd_opnd #(.NSRC(NSRC), .IW(IW), .DW(DW)) i_opnd (
        .src_vld  (src_vld),
        .src_idx  (src_idx),
        .src_data (src_data),
        .op_idx   (k_idx[k]),
        .op_busy  (k_busy[k]),
        .rf_data  (k_rf[k]),
        .op_data  (k_out[k]),
        .op_fwd   (k_fwd[k]),
        .op_ready (k_rdy[k])
      );
    end
  endgenerate

  assign opa_data = k_out[0];
  assign opb_data = k_out[1];
  assign opa_fwd  = k_fwd[0];
  assign opb_fwd  = k_fwd[1];
  assign rd_stall = |(k_use & ~k_rdy);

endmodule

// File: rtl/opfwd_chk.sv
module opfwd_chk #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned IW   = 5,
  parameter int unsigned DW   = 32
) (
  input logic [NSRC-1:0]    src_vld,
  input logic [NSRC*IW-1:0] src_idx,
  input logic [NSRC*DW-1:0] src_data,
  input logic [IW-1:0]      opa_idx,
  input logic [IW-1:0]      opb_idx,
  input logic               opa_use,
  input logic               opb_use,
  input logic               opa_busy,
  input logic               opb_busy,
  input logic [DW-1:0]      rfa_data,
  input logic [DW-1:0]      rfb_data,
  input logic [DW-1:0]      opa_data,
  input logic [DW-1:0]      opb_data,
  input logic               opa_fwd,
  input logic               opb_fwd,
  input logic               rd_stall
);

  logic a_supplied;
  logic b_supplied;

  always_comb begin
    a_supplied = 1'b0;
    b_supplied = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_vld[s] && src_idx[s*IW +: IW] == opa_idx && src_data[s*DW +: DW] == opa_data)
        a_supplied = 1'b1;
      if (src_vld[s] && src_idx[s*IW +: IW] == opb_idx && src_data[s*DW +: DW] == opb_data)
        b_supplied = 1'b1;
    end
  end

  always_comb begin
    a_r1_zero_a : assert (opa_idx != '0 || (opa_data == '0 && !opa_fwd));
    a_r1_zero_b : assert (opb_idx != '0 || (opb_data == '0 && !opb_fwd));
    a_r2_free_a : assert (opa_idx == '0 || opa_busy || (opa_data == rfa_data && !opa_fwd));
    a_r2_free_b : assert (opb_idx == '0 || opb_busy || (opb_data == rfb_data && !opb_fwd));
    a_r5_src_a  : assert (!opa_fwd || a_supplied);
    a_r5_src_b  : assert (!opb_fwd || b_supplied);
    a_r6_stall  : assert (!(opa_use && opa_busy && opa_idx != '0 && !opa_fwd) || rd_stall);
    a_r7_cover  : assert (rd_stall || !opa_use || !opa_busy || opa_idx == '0 || opa_fwd);
    a_r8_unused : assert (opa_use || opb_use || !rd_stall);
  end

endmodule

bind opfwd_top opfwd_chk #(.NSRC(NSRC), .IW(IW), .DW(DW)) i_opfwd_chk (
  .src_vld  (src_vld),
  .src_idx  (src_idx),
  .src_data (src_data),
  .opa_idx  (opa_idx),
  .opb_idx  (opb_idx),
  .opa_use  (opa_use),
  .opb_use  (opb_use),
  .opa_busy (opa_busy),
  .opb_busy (opb_busy),
  .rfa_data (rfa_data),
  .rfb_data (rfb_data),
  .opa_data (opa_data),
  .opb_data (opb_data),
  .opa_fwd  (opa_fwd),
  .opb_fwd  (opb_fwd),
  .rd_stall (rd_stall)
);

// File: tb/test_opfwd_top.sv
module test_opfwd_top;

  localparam int unsigned NSRC = 4;
  localparam int unsigned IW   = 5;
  localparam int unsigned DW   = 32;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;
  int   cyc;

  logic [NSRC-1:0]    src_vld;
  logic [NSRC*IW-1:0] src_idx;
  logic [NSRC*DW-1:0] src_data;
  logic [IW-1:0]      opa_idx, opb_idx;
  logic               opa_use, opb_use, opa_busy, opb_busy;
  logic [DW-1:0]      rfa_data, rfb_data;
  logic [DW-1:0]      opa_data, opb_data;
  logic               opa_fwd, opb_fwd, rd_stall;

  opfwd_top #(.NSRC(NSRC), .IW(IW), .DW(DW)) i_opfwd_top (
    .src_vld (src_vld), .src_idx (src_idx), .src_data (src_data),
    .opa_idx (opa_idx), .opb_idx (opb_idx),
    .opa_use (opa_use), .opb_use (opb_use),
    .opa_busy(opa_busy), .opb_busy(opb_busy),
    .rfa_data(rfa_data), .rfb_data(rfb_data),
    .opa_data(opa_data), .opb_data(opb_data),
    .opa_fwd (opa_fwd), .opb_fwd (opb_fwd),
    .rd_stall(rd_stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_vld = '0; src_idx = '0; src_data = '0;
    opa_idx = 5'd1; opb_idx = 5'd2;
    opa_use = 1'b1; opb_use = 1'b1;
    opa_busy = 1'b0; opb_busy = 1'b0;
    rfa_data = 32'hAAAA_0001; rfb_data = 32'hBBBB_0002;
  endtask

  task automatic set_src(input int s, input logic v, input logic [IW-1:0] ix, input logic [DW-1:0] d);
    src_vld[s] = v;
    src_idx[s*IW +: IW] = ix;
    src_data[s*DW +: DW] = d;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_quiet();
    @(posedge clk); idle(); settle();
    chk("R2 quiet A", opa_data, 32'hAAAA_0001);
    chk("R2 quiet B", opb_data, 32'hBBBB_0002);
    chk("R7 quiet stall", {31'd0, rd_stall}, 32'd0);
  endtask

  task automatic t_reg0();
    @(posedge clk); idle();
    opa_idx = 5'd0; opa_busy = 1'b1;
    set_src(0, 1'b1, 5'd0, 32'hDEAD_BEEF);
    settle();
    chk("R1 data", opa_data, 32'd0);
    chk("R1 fwd", {31'd0, opa_fwd}, 32'd0);
    chk("R1 stall", {31'd0, rd_stall}, 32'd0);
  endtask

  task automatic t_free();
    @(posedge clk); idle();
    set_src(1, 1'b1, 5'd1, 32'h1234_5678);
    settle();
    chk("R2 free data", opa_data, 32'hAAAA_0001);
    chk("R2 free fwd", {31'd0, opa_fwd}, 32'd0);
  endtask

  task automatic t_single();
    for (int s = 0; s < NSRC; s++) begin
      @(posedge clk); idle();
      opa_busy = 1'b1;
      set_src(s, 1'b1, 5'd1, 32'h5000_0000 + s);
      settle();
      chk("R3 single data", opa_data, 32'h5000_0000 + s);
      chk("R3 single fwd", {31'd0, opa_fwd}, 32'd1);
      chk("R3 single stall", {31'd0, rd_stall}, 32'd0);
    end
  endtask

  task automatic t_priority();
    for (int low = 0; low < NSRC; low++) begin
      @(posedge clk); idle();
      opa_busy = 1'b1;
      for (int s = low; s < NSRC; s++) set_src(s, 1'b1, 5'd1, 32'h7000_0000 + s);
      settle();
      chk("R4 earliest wins", opa_data, 32'h7000_0000 + low);
    end
  endtask

  task automatic t_ignore();
    @(posedge clk); idle();
    opa_busy = 1'b1;
    set_src(0, 1'b0, 5'd1, 32'h0BAD_0000);
    set_src(1, 1'b1, 5'd9, 32'h0BAD_0001);
    set_src(2, 1'b1, 5'd1, 32'h600D_0002);
    settle();
    chk("R5 skip invalid/mismatch", opa_data, 32'h600D_0002);
    @(posedge clk);
    set_src(2, 1'b0, 5'd1, 32'h600D_0002);
    settle();
    chk("R5 none supplies fwd", {31'd0, opa_fwd}, 32'd0);
    chk("R6 uncovered stall", {31'd0, rd_stall}, 32'd1);
  endtask

  task automatic t_cover_both();
    @(posedge clk); idle();
    opa_busy = 1'b1; opb_busy = 1'b1;
    set_src(1, 1'b1, 5'd1, 32'hA0A0_0001);
    set_src(3, 1'b1, 5'd2, 32'hB0B0_0003);
    settle();
    chk("R9 A from memory", opa_data, 32'hA0A0_0001);
    chk("R9 B from rf write", opb_data, 32'hB0B0_0003);
    chk("R7 both covered", {31'd0, rd_stall}, 32'd0);
    @(posedge clk);
    opb_busy = 1'b0;
    settle();
    chk("R9 B from regfile", opb_data, 32'hBBBB_0002);
    chk("R9 A still fwd", {31'd0, opa_fwd}, 32'd1);
  endtask

  task automatic t_overlap();
    @(posedge clk); idle();
    opa_busy = 1'b1; opb_busy = 1'b1;
    for (int s = 0; s < NSRC; s++) set_src(s, 1'b1, 5'd1, 32'hC000_0000 + s);
    settle();
    chk("R4 overlap A", opa_data, 32'hC000_0000);
    chk("R6 overlap stall from B", {31'd0, rd_stall}, 32'd1);
    @(posedge clk);
    opb_use = 1'b0;
    settle();
    chk("R8 unused B no stall", {31'd0, rd_stall}, 32'd0);
    chk("R4 overlap A kept", opa_data, 32'hC000_0000);
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0;
    rst_n = 1'b0;
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_quiet();
    t_reg0();
    t_free();
    t_single();
    t_priority();
    t_ignore();
    t_cover_both();
    t_overlap();
    @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule